// File: doc/BRIEF.md
# Configurable Logic Cell

This block models a single programmable logic cell of a lookup-table fabric. Two 4-input truth tables (F and G) each produce one bit from their own four input pins. A third, 3-input table (H) combines the F result, the G result and one extra bit taken from the control pins. With H set up as a 2:1 selector, the cell computes any function of five inputs. Two flip-flops can register the cell's two outputs. Each flip-flop has its own data source, its own behaviour under set/reset, and its own choice of a registered or a direct output.

Four shared control pins are steered by configuration onto four internal signals: the extra H input, a direct data bit, a clock enable and an asynchronous set/reset. In memory mode the F and G tables together act as a 32 x 1 synchronous RAM. The F pins give the word address, the H input picks the F or G half, and the direct data bit is written at the clock edge when the write-enable pin is high.

The whole configuration is loaded through a serial shift port. It can be reloaded at any time, which changes the cell's function.

Top module: `clb_cell`

## Requirements
- R1: With `cfg_shift_en` high, each clock edge shifts `cfg_shift_din` into a 57-bit chain, and both outputs read 0. The chain order is: F table, then G table, then the control word. The last bit sent lands in F table bit 0, and the first bit sent lands in control word bit 24.
- R2: When Y is not registered, `out_y` equals G table bit `g_in`.
- R3: When X is not registered, `out_x` equals H table bit {h1, G result, F result}, where h1 is the most significant bit of that index.
- R4: With the H table set to 8'hCA and `g_in` equal to `f_in`, `out_x` is bit {h1, f_in} of the 32-bit value {G table, F table}. This is an arbitrary 5-input function.
- R5: The control word holds four 2-bit selectors: h1 at [9:8], data at [11:10], enable at [13:12] and set/reset at [15:14]. Each selector picks the `ctrl_in` bit that drives that internal signal. The H table is at [7:0].
- R6: The source code at [17:16] (X) or [19:18] (Y) selects the flip-flop's data: 0 for F, 1 for G, 2 for H, 3 for the data bit. With the register bits [22] (X) and [23] (Y) set, the output shows the value captured at the previous edge.
- R7: While the steered clock enable is low, the registered outputs keep their value across clock edges.
- R8: While the steered set/reset is high, each flip-flop at once takes the value of its set bit, [20] for X and [21] for Y, without waiting for a clock. Clock edges do not change it while set/reset stays high.
- R9: With memory mode bit [24] set and `ram_we` high, a clock edge writes the data bit into table bit `f_in`. The target is the F table when h1 is 0 and the G table when h1 is 1. The written bit can then be read back through the outputs.
- R10: With memory mode clear, `ram_we` has no effect on either table.
- R11: After reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Serial configuration shift enable |
| cfg_shift_din | input | 1 | Serial configuration data |
| f_in | input | 4 | F table inputs, also the RAM address |
| g_in | input | 4 | G table inputs |
| ctrl_in | input | 4 | Shared control pins steered by configuration |
| ram_we | input | 1 | Write enable in memory mode |
| out_x | output | 1 | X output, from H directly or from the X flip-flop |
| out_y | output | 1 | Y output, from G directly or from the Y flip-flop |

## Verification
The assertions check on every cycle that the outputs stay quiet while configuration is shifting, and that a table never changes without a shift or a write. They also check that a write stores its data bit at its address, that a flip-flop held by set/reset shows its set value, and that a disabled flip-flop does not move. The truth-table contents, the H combination, the 5-input function and the read-back of RAM words depend on the loaded configuration. These can only be shown by the bench's sweeps over random tables and all input codes.

// File: rtl/clb_pkg.sv
package clb_pkg;
    localparam int LUT_K     = 4;
    localparam int LUT_BITS  = 1 << LUT_K;
    localparam int HLUT_K    = 3;
    localparam int HLUT_BITS = 1 << HLUT_K;
    localparam int NUM_CTRL  = 4;
    localparam int SEL_W     = $clog2(NUM_CTRL);
    localparam int NUM_FF    = 2;

    typedef enum logic [1:0] {
        SRC_F   = 2'd0,
        SRC_G   = 2'd1,
        SRC_H   = 2'd2,
        SRC_DIN = 2'd3
    } ff_src_e;

    typedef struct packed {
        logic                  ram_mode;
        logic [NUM_FF-1:0]     reg_out;
        logic [NUM_FF-1:0]     sr_set;
        ff_src_e               src_y;
        ff_src_e               src_x;
        logic [SEL_W-1:0]      sr_sel;
        logic [SEL_W-1:0]      ec_sel;
        logic [SEL_W-1:0]      din_sel;
        logic [SEL_W-1:0]      h1_sel;
        logic [HLUT_BITS-1:0]  h_tbl;
    } ctrl_cfg_t;

    localparam int CTRL_W = $bits(ctrl_cfg_t);
endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic         shift_out,
    input  logic         wr_en,
    input  logic [K-1:0] wr_addr,
    input  logic         wr_data,
    input  logic [K-1:0] rd_addr,
    output logic         rd_out
);
    localparam int DEPTH = 1 << K;

    logic [DEPTH-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (shift_en) begin
            tbl_d = {tbl_q[DEPTH-2:0], shift_in};
        end else if (wr_en) begin
            tbl_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign shift_out = tbl_q[DEPTH-1];
    assign rd_out    = tbl_q[rd_addr];

    assert_table_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !wr_en) |=> $stable(tbl_q));

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !shift_en) |=> (tbl_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/clb_ff.sv
module clb_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sr,
    input  logic sr_val,
    input  logic d,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = ce ? d : q_q;
    end

    always_ff @(posedge clk or negedge rst_n or posedge sr) begin
        if (!rst_n)  q_q <= 1'b0;
        else if (sr) q_q <= sr_val;
        else         q_q <= q_d;
    end

    assign q = q_q;

    assert_sr_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sr && $past(sr)) |-> (q_q == sr_val));

    assert_hold_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !sr) |=> ($stable(q_q) || sr));
endmodule

// File: rtl/clb_cell.sv
module clb_cell
    import clb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_shift_en,
    input  logic                cfg_shift_din,
    input  logic [LUT_K-1:0]    f_in,
    input  logic [LUT_K-1:0]    g_in,
    input  logic [NUM_CTRL-1:0] ctrl_in,
    input  logic                ram_we,
    output logic                out_x,
    output logic                out_y
);
    ctrl_cfg_t cfg_d, cfg_q;
    logic      f_chain, g_chain;
    logic      f_res, g_res, h_res;
    logic      h1_s, din_s, ec_s, sr_s;
    logic      wr_f, wr_g;
    logic [NUM_FF-1:0] ff_d, ff_q;
    ff_src_e   src [NUM_FF];

    // steering of the shared control pins
    assign h1_s  = ctrl_in[cfg_q.h1_sel];
    assign din_s = ctrl_in[cfg_q.din_sel];
    assign ec_s  = ctrl_in[cfg_q.ec_sel];
    assign sr_s  = ctrl_in[cfg_q.sr_sel];

    assign wr_f = cfg_q.ram_mode && ram_we && !cfg_shift_en && !h1_s;
    assign wr_g = cfg_q.ram_mode && ram_we && !cfg_shift_en &&  h1_s;

    clb_lut #(.K(LUT_K)) f_lut_i (
        .clk(clk), .rst_n(rst_n),
        .shift_en(cfg_shift_en), .shift_in(cfg_shift_din), .shift_out(f_chain),
        .wr_en(wr_f), .wr_addr(f_in), .wr_data(din_s),
        .rd_addr(f_in), .rd_out(f_res)
    );

    clb_lut #(.K(LUT_K)) g_lut_i (
        .clk(clk), .rst_n(rst_n),
        .shift_en(cfg_shift_en), .shift_in(f_chain), .shift_out(g_chain),
        .wr_en(wr_g), .wr_addr(f_in), .wr_data(din_s),
        .rd_addr(g_in), .rd_out(g_res)
    );

    assign h_res = cfg_q.h_tbl[{h1_s, g_res, f_res}];

    // control word: tail of the configuration chain
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_shift_en) begin
            cfg_d = ctrl_cfg_t'({cfg_q[CTRL_W-2:0], g_chain});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign src[0] = cfg_q.src_x;
    assign src[1] = cfg_q.src_y;

    generate
        for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
            always_comb begin
                unique case (src[i])
                    SRC_F:   ff_d[i] = f_res;
                    SRC_G:   ff_d[i] = g_res;
                    SRC_H:   ff_d[i] = h_res;
                    default: ff_d[i] = din_s;
                endcase
            end

            clb_ff ff_i (
                .clk(clk), .rst_n(rst_n),
                .ce(ec_s && !cfg_shift_en),
                .sr(sr_s && !cfg_shift_en),
                .sr_val(cfg_q.sr_set[i]),
                .d(ff_d[i]),
                .q(ff_q[i])
            );
        end
    endgenerate

    always_comb begin
        if (cfg_shift_en) begin
            out_x = 1'b0;
            out_y = 1'b0;
        end else begin
            out_x = cfg_q.reg_out[0] ? ff_q[0] : h_res;
            out_y = cfg_q.reg_out[1] ? ff_q[1] : g_res;
        end
    end

    assert_quiet_during_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |-> (!out_x && !out_y));
endmodule

// File: tb/clb_cell_tb.sv
module clb_cell_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TOTAL_W    = 57;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_shift_en = 1'b0;
    logic       cfg_shift_din = 1'b0;
    logic [3:0] f_in = '0;
    logic [3:0] g_in = '0;
    logic [3:0] ctrl_in = '0;
    logic       ram_we = 1'b0;
    logic       out_x, out_y;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clb_cell dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_shift_en(cfg_shift_en), .cfg_shift_din(cfg_shift_din),
        .f_in(f_in), .g_in(g_in), .ctrl_in(ctrl_in), .ram_we(ram_we),
        .out_x(out_x), .out_y(out_y)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // control word: h1 on ctrl[0], data on ctrl[1], enable on ctrl[2], set/reset on ctrl[3]
    function automatic logic [24:0] mkctrl(input logic ram, input logic [1:0] regs,
                                           input logic [1:0] sets, input logic [1:0] sy,
                                           input logic [1:0] sx, input logic [7:0] h);
        return {ram, regs, sets, sy, sx, 2'd3, 2'd2, 2'd1, 2'd0, h};
    endfunction

    task automatic load(input logic [15:0] ft, input logic [15:0] gt, input logic [24:0] c);
        logic [TOTAL_W-1:0] v;
        v = {c, gt, ft};
        @(negedge clk);
        cfg_shift_en = 1'b1;
        for (int i = TOTAL_W - 1; i >= 0; i--) begin
            cfg_shift_din = v[i];
            @(posedge clk);
            if (i == 20) begin
                #1;
                check("R1 quiet x", out_x, 1'b0);
                check("R1 quiet y", out_y, 1'b0);
            end
            @(negedge clk);
        end
        cfg_shift_en = 1'b0;
    endtask

    function automatic logic hval(input logic [15:0] ft, input logic [15:0] gt,
                                  input logic [7:0] h, input logic [3:0] fa,
                                  input logic [3:0] ga, input logic h1);
        return h[{h1, gt[ga], ft[fa]}];
    endfunction

    initial begin
        logic [15:0] ft, gt;
        logic [7:0]  ht;
        logic [31:0] fn, ram_img;
        logic        ex, ey, hx;

        #(3*CLK_PERIOD) rst_n = 1'b1;
        #1;
        check("R11 reset x", out_x, 1'b0);
        check("R11 reset y", out_y, 1'b0);

        // R2, R3, R5: random tables, full sweep of inputs
        for (int t = 0; t < 4; t++) begin
            ft = 16'($urandom); gt = 16'($urandom); ht = 8'($urandom);
            load(ft, gt, mkctrl(1'b0, 2'b00, 2'b00, 2'd0, 2'd0, ht));
            for (int k = 0; k < 512; k++) begin
                f_in = k[3:0]; g_in = k[7:4]; ctrl_in = {3'b000, k[8]};
                #1;
                check("R2 out_y=G", out_y, gt[g_in]);
                check("R3 R5 out_x=H", out_x, hval(ft, gt, ht, f_in, g_in, k[8]));
            end
        end

        // R4: 5-input function through H as a selector
        fn = $urandom;
        load(fn[15:0], fn[31:16], mkctrl(1'b0, 2'b00, 2'b00, 2'd0, 2'd0, 8'hCA));
        for (int k = 0; k < 32; k++) begin
            f_in = k[3:0]; g_in = k[3:0]; ctrl_in = {3'b000, k[4]};
            #1;
            check("R4 five-input", out_x, fn[k]);
        end

        // R6: flip-flop source select, registered outputs
        for (int s = 0; s < 4; s++) begin
            ft = 16'($urandom); gt = 16'($urandom); ht = 8'($urandom);
            load(ft, gt, mkctrl(1'b0, 2'b11, 2'b00, 2'(s), 2'(s), ht));
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                f_in = 4'($urandom); g_in = 4'($urandom);
                ctrl_in = {2'b01, 1'($urandom), 1'($urandom)};
                hx = hval(ft, gt, ht, f_in, g_in, ctrl_in[0]);
                case (s)
                    0: ex = ft[f_in];
                    1: ex = gt[g_in];
                    2: ex = hx;
                    default: ex = ctrl_in[1];
                endcase
                @(posedge clk); #1;
                check("R6 reg x", out_x, ex);
                check("R6 reg y", out_y, ex);
            end
            // R7: enable low holds
            @(negedge clk);
            ctrl_in = 4'b0000; f_in = ~f_in; g_in = ~g_in;
            repeat (3) @(posedge clk);
            #1;
            check("R7 hold x", out_x, ex);
            check("R7 hold y", out_y, ex);
        end

        // R8: asynchronous set/reset with per-flop value
        load(16'h0000, 16'h0000, mkctrl(1'b0, 2'b11, 2'b01, 2'd3, 2'd3, 8'h00));
        @(negedge clk);
        ctrl_in = 4'b0110;
        @(posedge clk); #1;
        check("R8 pre x", out_x, 1'b1);
        @(negedge clk);
        ctrl_in = 4'b1100;
        #1;
        check("R8 async set x", out_x, 1'b1);
        check("R8 async reset y", out_y, 1'b0);
        ctrl_in = 4'b1110;
        @(posedge clk); #1;
        check("R8 clock ignored x", out_x, 1'b1);
        check("R8 clock ignored y", out_y, 1'b0);
        @(negedge clk);
        ctrl_in = 4'b0000;

        // R9: RAM write then read-back
        load(16'h0000, 16'h0000, mkctrl(1'b1, 2'b00, 2'b00, 2'd0, 2'd0, 8'hCA));
        ram_img = $urandom;
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            f_in = a[3:0]; ctrl_in = {2'b00, ram_img[a], a[4]}; ram_we = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        ram_we = 1'b0;
        for (int a = 0; a < 32; a++) begin
            f_in = a[3:0]; g_in = a[3:0]; ctrl_in = {3'b000, a[4]};
            #1;
            check("R9 ram read", out_x, ram_img[a]);
        end

        // R10: write enable ignored outside memory mode
        ft = 16'($urandom); gt = 16'($urandom);
        load(ft, gt, mkctrl(1'b0, 2'b00, 2'b00, 2'd0, 2'd0, 8'hCA));
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            f_in = 4'(a); ctrl_in = {2'b00, ~ft[a], a[0]}; ram_we = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        ram_we = 1'b0;
        for (int a = 0; a < 32; a++) begin
            f_in = a[3:0]; g_in = a[3:0]; ctrl_in = {3'b000, a[4]};
            #1;
            ey = a[4] ? gt[a[3:0]] : ft[a[3:0]];
            check("R10 tables intact", out_x, ey);
        end

        // R11: reset mid-operation clears outputs
        load(16'hFFFF, 16'hFFFF, mkctrl(1'b0, 2'b11, 2'b00, 2'd0, 2'd0, 8'hFF));
        @(negedge clk);
        ctrl_in = 4'b0100;
        @(posedge clk); #1;
        rst_n = 1'b0;
        #1;
        check("R11 reset x", out_x, 1'b0);
        check("R11 reset y", out_y, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule